// File: doc/BRIEF.md
# Bidirectional Port with Wired-OR Option

This block is an eight-pin general-purpose I/O port. Software reaches three registers over a small register bus: an output latch, a per-pin direction register, and an option register. The option register holds a single open-drain enable that turns off every pull-up driver while leaving the pull-down drivers working. With that bit set, several ports can share a line through an external pull-up. The pad is modelled by two enables per pin, one for the pull-up driver and one for the pull-down driver. When both are low the pin floats.

An operating-mode input chooses single-chip or expanded behaviour, and the port samples it while reset is asserted. In expanded mode the upper four pins can carry chip-select strobes that are decoded elsewhere. The option register holds one enable per pin for these strobes. After a reset in expanded mode, pin 7 comes up as the program chip-select output; in single-chip mode it comes up as a floating input. Each pin level passes through a two-flop synchronizer before software can read it.

Top module: `wor_port`

## Requirements
- R1: After a reset in single-chip mode (`exp_mode`=0), every pin has `pu_en`=0 and `pd_en`=0, and the data, direction and option registers all read 0.
- R2: After a reset in expanded mode (`exp_mode`=1), the option register reads 8'h80, meaning the pin 7 chip-select enable is set. Pin 7 then follows `cs_in[3]` as a push-pull output, and pins 6..0 float.
- R3: With open-drain off and no chip-select override, a pin whose direction bit is 0 has both enables at 0. A pin whose direction bit is 1 drives its latch bit: `pu_en`=1 when the latch bit is 1, and `pd_en`=1 when it is 0.
- R4: When option bit 0 (open-drain) is 1, `pu_en` is 0 on every pin in every mode. `pd_en` behaves exactly as it does with the bit cleared.
- R5: A read at offset 0 returns the latch bit for pins whose direction bit is 1, and the synchronized pin level for pins whose direction bit is 0.
- R6: A write at offset 0 always loads the output latch, including the bits of input pins. A pin shows its latched value as soon as its direction bit is set to 1.
- R7: A change on `pin_in` becomes visible at offset 0 after exactly two rising clock edges. After one edge the read still returns the previous level.
- R8: Offset 0 is the data register and offset 1 is the direction register. Offset 2 is the option register: bit 0 is open-drain, bits 7..4 are the chip-select enables for pins 7..4, and bits 3..1 read 0. Offset 3 ignores writes and reads 0. A register write takes effect at the next rising edge.
- R9: In expanded mode, when the enable for pin 4+k is set, that pin drives `cs_in[k]` and ignores its direction and latch bits, while open-drain still applies. The mapping is `cs_in[3]`=program (pin 7), `cs_in[2]`=general (pin 6), `cs_in[1]`=I/O 1 (pin 5) and `cs_in[0]`=I/O 2 (pin 4).
- R10: In single-chip mode the chip-select enables have no effect on the pins, which follow the direction and latch bits only.
- R11: `pu_en` and `pd_en` are never both 1 on the same pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exp_mode | input | 1 | Operating mode: 1 = expanded, 0 = single-chip; sampled during reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pin_in | input | 8 | Sensed pin levels (asynchronous) |
| cs_in | input | 4 | Chip-select strobes from the external decoder |
| pu_en | output | 8 | Pull-up driver enable per pin |
| pd_en | output | 8 | Pull-down driver enable per pin |

## Verification
The assertions assume that `exp_mode` changes only while `rst` is high. They also assume that `pin_in`, `cs_in` and the bus inputs always carry defined values, because the synchronizer-latency and register-write properties compare them through `$past`. The bench changes the mode only inside its reset task. It drives every input to a known value from time zero, and it changes inputs only away from the rising edge, so each sampled value is unambiguous.

// File: rtl/wor_port_pkg.sv
package wor_port_pkg;
    parameter int PORT_W = 8;
    parameter int CS_N   = 4;
    parameter int ADDR_W = 2;

    localparam int OPT_OD_BIT = 0;
    localparam int CS_BASE    = PORT_W - CS_N;

    typedef enum logic [ADDR_W-1:0] {
        OFS_DATA = 2'd0,
        OFS_DIR  = 2'd1,
        OFS_OPT  = 2'd2,
        OFS_NONE = 2'd3
    } ofs_e;
endpackage

// File: rtl/wor_port_sync.sv
module wor_port_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_in;
        st_d.stable = st_q.meta;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sync_out = st_q.stable;
endmodule

// File: rtl/wor_port_regs.sv
module wor_port_regs
    import wor_port_pkg::*;
#(
    parameter int W     = PORT_W,
    parameter int NCS   = CS_N,
    parameter int AW    = ADDR_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           exp_mode,
    input  logic           wr,
    input  logic [AW-1:0]  addr,
    input  logic [W-1:0]   wdata,
    input  logic [W-1:0]   pins_sync,
    output logic [W-1:0]   rdata,
    output logic [W-1:0]   data_q,
    output logic [W-1:0]   dir_q,
    output logic           od_q,
    output logic [NCS-1:0] cs_en_q
);
    localparam logic [NCS-1:0] CS_RST_EXP = NCS'(1) << (NCS - 1);

    typedef struct packed {
        logic [W-1:0]   data;
        logic [W-1:0]   dir;
        logic           od;
        logic [NCS-1:0] cs_en;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr) begin
            case (ofs_e'(addr))
                OFS_DATA: r_d.data = wdata;
                OFS_DIR:  r_d.dir  = wdata;
                OFS_OPT: begin
                    r_d.od    = wdata[OPT_OD_BIT];
                    r_d.cs_en = wdata[W-1 -: NCS];
                end
                default: ;
            endcase
        end
        if (rst) begin
            r_d.data  = '0;
            r_d.dir   = '0;
            r_d.od    = 1'b0;
            r_d.cs_en = exp_mode ? CS_RST_EXP : '0;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        case (ofs_e'(addr))
            OFS_DATA: rdata = (r_q.dir & r_q.data) | (~r_q.dir & pins_sync);
            OFS_DIR:  rdata = r_q.dir;
            OFS_OPT: begin
                rdata[OPT_OD_BIT] = r_q.od;
                rdata[W-1 -: NCS] = r_q.cs_en;
            end
            default:  rdata = '0;
        endcase
    end

    assign data_q  = r_q.data;
    assign dir_q   = r_q.dir;
    assign od_q    = r_q.od;
    assign cs_en_q = r_q.cs_en;
endmodule

// File: rtl/wor_port_drv.sv
module wor_port_drv #(
    parameter int W   = 8,
    parameter int NCS = 4
) (
    input  logic           exp_mode,
    input  logic [W-1:0]   data_q,
    input  logic [W-1:0]   dir_q,
    input  logic           od_q,
    input  logic [NCS-1:0] cs_en_q,
    input  logic [NCS-1:0] cs_in,
    output logic [W-1:0]   pu_en,
    output logic [W-1:0]   pd_en
);
    localparam int BASE = W - NCS;

    logic [W-1:0] drv_val;
    logic [W-1:0] drv_oe;

    for (genvar i = 0; i < W; i++) begin : g_pin
        if (i >= BASE) begin : g_alt
            logic use_cs;
            assign use_cs     = exp_mode & cs_en_q[i-BASE];
            assign drv_val[i] = use_cs ? cs_in[i-BASE] : data_q[i];
            assign drv_oe[i]  = use_cs | dir_q[i];
        end else begin : g_plain
            assign drv_val[i] = data_q[i];
            assign drv_oe[i]  = dir_q[i];
        end
        assign pu_en[i] = drv_oe[i] & drv_val[i] & ~od_q;
        assign pd_en[i] = drv_oe[i] & ~drv_val[i];
    end
endmodule

// File: rtl/wor_port.sv
module wor_port
    import wor_port_pkg::*;
#(
    parameter int W   = PORT_W,
    parameter int NCS = CS_N,
    parameter int AW  = ADDR_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           exp_mode,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [W-1:0]   bus_wdata,
    output logic [W-1:0]   bus_rdata,
    input  logic [W-1:0]   pin_in,
    input  logic [NCS-1:0] cs_in,
    output logic [W-1:0]   pu_en,
    output logic [W-1:0]   pd_en
);
    logic [W-1:0]   sync_pins;
    logic [W-1:0]   data_q;
    logic [W-1:0]   dir_q;
    logic           od_q;
    logic [NCS-1:0] cs_en_q;

    wor_port_sync #(.W(W)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (sync_pins)
    );

    wor_port_regs #(.W(W), .NCS(NCS), .AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .exp_mode  (exp_mode),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .pins_sync (sync_pins),
        .rdata     (bus_rdata),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .od_q      (od_q),
        .cs_en_q   (cs_en_q)
    );

    wor_port_drv #(.W(W), .NCS(NCS)) u_drv (
        .exp_mode (exp_mode),
        .data_q   (data_q),
        .dir_q    (dir_q),
        .od_q     (od_q),
        .cs_en_q  (cs_en_q),
        .cs_in    (cs_in),
        .pu_en    (pu_en),
        .pd_en    (pd_en)
    );
endmodule

// File: rtl/wor_port_chk.sv
module wor_port_chk #(
    parameter int W   = 8,
    parameter int NCS = 4,
    parameter int AW  = 2
) (
    input logic           clk,
    input logic           rst,
    input logic           exp_mode,
    input logic           bus_wr,
    input logic [AW-1:0]  bus_addr,
    input logic [W-1:0]   bus_wdata,
    input logic [W-1:0]   pin_in,
    input logic [NCS-1:0] cs_in,
    input logic [W-1:0]   pu_en,
    input logic [W-1:0]   pd_en,
    input logic [W-1:0]   dir_q,
    input logic           od_q,
    input logic [NCS-1:0] cs_en_q,
    input logic [W-1:0]   sync_pins
);
    localparam logic [NCS-1:0] CS_RST_EXP = NCS'(1) << (NCS - 1);
    localparam logic [W-1:0]   LOW_MASK   = W'((1 << (W - NCS)) - 1);

    logic [1:0] cyc_q;
    always_ff @(posedge clk) begin
        if (rst)               cyc_q <= 2'd0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
    end

    p_no_contention_r11: assert property (@(posedge clk) disable iff (rst)
        (pu_en & pd_en) == '0);

    p_od_pullup_off_r4: assert property (@(posedge clk) disable iff (rst)
        od_q |-> (pu_en == '0));

    p_low_input_idle_r3: assert property (@(posedge clk) disable iff (rst)
        ((pu_en | pd_en) & ~dir_q & LOW_MASK) == '0);

    p_single_no_cs_r10: assert property (@(posedge clk) disable iff (rst)
        !exp_mode |-> (((pu_en | pd_en) & ~dir_q) == '0));

    p_sync_two_edges_r7: assert property (@(posedge clk) disable iff (rst)
        (cyc_q >= 2'd2) |-> (sync_pins == $past(pin_in, 2)));

    p_dir_write_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd1) |=> (dir_q == $past(bus_wdata)));

    p_reset_exp_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && exp_mode) |-> (cs_en_q == CS_RST_EXP));

    p_cs_pin7_r9: assert property (@(posedge clk) disable iff (rst)
        (exp_mode && cs_en_q[NCS-1]) |-> (pd_en[W-1] == !cs_in[NCS-1]));
endmodule

bind wor_port wor_port_chk #(.W(W), .NCS(NCS), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .exp_mode  (exp_mode),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_in    (pin_in),
    .cs_in     (cs_in),
    .pu_en     (pu_en),
    .pd_en     (pd_en),
    .dir_q     (dir_q),
    .od_q      (od_q),
    .cs_en_q   (cs_en_q),
    .sync_pins (sync_pins)
);

// File: tb/wor_port_test.sv
module wor_port_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       exp_mode = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'd0;
    logic [3:0] cs_in = 4'd0;
    logic [7:0] pu_en;
    logic [7:0] pd_en;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wor_port uut (
        .clk       (clk),
        .rst       (rst),
        .exp_mode  (exp_mode),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .cs_in     (cs_in),
        .pu_en     (pu_en),
        .pd_en     (pd_en)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst = 1'b1;
        exp_mode = mode;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Expected {pu, pd} from the requirement text (R3, R4, R9, R10)
    function automatic logic [15:0] model(input logic mode, input logic [3:0] en,
                                          input logic [3:0] cs, input logic [7:0] dir,
                                          input logic [7:0] dat, input logic od);
        logic [7:0] pu, pd;
        pu = '0;
        pd = '0;
        for (int i = 0; i < 8; i++) begin
            logic v, oe;
            v  = dat[i];
            oe = dir[i];
            if (i >= 4 && mode && en[i-4]) begin
                v  = cs[i-4];
                oe = 1'b1;
            end
            pu[i] = oe & v & ~od;
            pd[i] = oe & ~v;
        end
        return {pu, pd};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic [7:0] prev_pin;

        // R1: reset state in single-chip mode
        do_reset(1'b0);
        #1;
        chk("R1 pins idle", {pu_en, pd_en}, 16'h0000);
        for (int a = 0; a < 4; a++) begin
            rd_reg(2'(a), r);
            chk("R1 register reads", {8'h00, r}, 16'h0000);
        end

        // R8: offset 3 ignores writes, option spare bits read zero
        wr_reg(2'd3, 8'hFF);
        rd_reg(2'd3, r);
        chk("R8 offset 3 reads zero", {8'h00, r}, 16'h0000);
        wr_reg(2'd2, 8'hFF);
        rd_reg(2'd2, r);
        chk("R8 option layout", {8'h00, r}, 16'h00F1);
        // R10: enables stored in single-chip mode do not touch pins
        wr_reg(2'd2, 8'hF0);
        for (int c = 0; c < 16; c++) begin
            cs_in = 4'(c);
            #1;
            chk("R10 no chip-select in single-chip", {pu_en, pd_en}, 16'h0000);
        end
        wr_reg(2'd2, 8'h00);

        // R6: latch loads while pins are inputs
        wr_reg(2'd0, 8'h5A);
        #1;
        chk("R6 input pins stay idle", {pu_en, pd_en}, 16'h0000);
        wr_reg(2'd1, 8'hFF);
        #1;
        chk("R6 latch shown on output", {pu_en, pd_en}, 16'h5AA5);
        rd_reg(2'd0, r);
        chk("R6 latch readback", {8'h00, r}, 16'h005A);

        // R3, R4, R8, R11: every direction pattern, two latch patterns, both open-drain settings
        for (int od = 0; od < 2; od++) begin
            wr_reg(2'd2, 8'(od));
            for (int p = 0; p < 2; p++) begin
                logic [7:0] pat;
                pat = (p == 0) ? 8'hA5 : 8'h5A;
                wr_reg(2'd0, pat);
                for (int d = 0; d < 256; d++) begin
                    wr_reg(2'd1, 8'(d));
                    #1;
                    chk(od ? "R4 open-drain drive" : "R3 push-pull drive",
                        {pu_en, pd_en}, model(1'b0, 4'h0, 4'h0, 8'(d), pat, od[0]));
                    chk("R11 no contention", {8'h00, pu_en & pd_en}, 16'h0000);
                    rd_reg(2'd1, r);
                    chk("R8 direction readback", {8'h00, r}, {8'h00, 8'(d)});
                end
            end
        end
        wr_reg(2'd2, 8'h00);

        // R5, R7: read mux and two-edge synchronizer latency
        wr_reg(2'd0, 8'h3C);
        prev_pin = pin_in;
        for (int d = 0; d < 256; d++) begin
            logic [7:0] np;
            np = 8'(d) ^ 8'h96;
            wr_reg(2'd1, 8'(d));
            pin_in = np;
            bus_addr = 2'd0;
            @(posedge clk);
            #1;
            chk("R7 one edge still old", {8'h00, bus_rdata},
                {8'h00, (8'(d) & 8'h3C) | (~8'(d) & prev_pin)});
            @(posedge clk);
            #1;
            chk("R5 data read mux", {8'h00, bus_rdata},
                {8'h00, (8'(d) & 8'h3C) | (~8'(d) & np)});
            prev_pin = np;
        end

        // R2: expanded-mode reset
        cs_in = 4'h0;
        do_reset(1'b1);
        rd_reg(2'd2, r);
        chk("R2 option after expanded reset", {8'h00, r}, 16'h0080);
        cs_in = 4'h8;
        #1;
        chk("R2 pin 7 program select high", {pu_en, pd_en}, 16'h8000);
        cs_in = 4'h0;
        #1;
        chk("R2 pin 7 program select low", {pu_en, pd_en}, 16'h0080);

        // R9, R4, R11: every enable mask and strobe pattern over two port settings
        for (int s = 0; s < 2; s++) begin
            logic [7:0] dv, dt;
            dv = (s == 0) ? 8'h00 : 8'hFF;
            dt = (s == 0) ? 8'h00 : 8'h0F;
            wr_reg(2'd1, dv);
            wr_reg(2'd0, dt);
            for (int od = 0; od < 2; od++) begin
                for (int en = 0; en < 16; en++) begin
                    wr_reg(2'd2, {4'(en), 3'b000, 1'(od)});
                    for (int c = 0; c < 16; c++) begin
                        cs_in = 4'(c);
                        #1;
                        chk("R9 chip-select override", {pu_en, pd_en},
                            model(1'b1, 4'(en), 4'(c), dv, dt, od[0]));
                        chk("R11 no contention", {8'h00, pu_en & pd_en}, 16'h0000);
                    end
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule